// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt Generator

This block drives the periodic interrupt line of a real-time clock. A 3-bit cycle code chooses between an idle line, a line held low, two free-running square waves (2 Hz and 1 Hz, 50% duty) that stay in phase with the second count, and four latched modes that fire once per second, minute, hour or month. In the latched modes the event sets a flag that holds the line low until the host clears it by writing 0.

The block runs on a fast system clock. A one-cycle enable marks each 32.768 kHz tick, and one-cycle strobes arrive from the time counters when the second, minute, hour or month advances. The square waves come from a tick divider. Each second-increment strobe re-aligns that divider, so the falling edge of every wave lands a fixed number of ticks before the second advances. The flag output gives the same information as the line, so software can poll it where no interrupt pin is wired.

Top module: `rtc_periodic_irq`

## Requirements
- R1: While `rst_n` is low, and until the first clock edge after its release, `irq_pull_low` and `irq_flag` are 0 whatever the cycle code is.
- R2: With cycle code 000 the line is released (`irq_pull_low` = 0) and the flag reads 0, whatever strobes arrive.
- R3: With cycle code 001 the line is held low and the flag reads 1.
- R4: With cycle code 011 (1 Hz) the line is low for ticks 0 to TICKS_PER_SEC/2-1 of each second and released for the rest. The tick phase is set to SYNC_DELAY on the edge that samples `sec_inc`. It advances by one, wrapping at TICKS_PER_SEC, on every other edge that samples `tick_32k`.
- R5: With cycle code 010 (2 Hz) the line is low in the first and third quarters of that same tick phase and released in the second and fourth quarters.
- R6: Cycle codes 100, 101, 110 and 111 select `sec_inc`, `min_inc`, `hour_inc` and `month_inc` respectively. The selected strobe sets the flag at the clock edge that samples it, and the line is low while the flag is set.
- R7: In a latched mode, strobes other than the selected one do not set the flag.
- R8: A write (`flag_wr` = 1) with `flag_wdata` = 0 clears the flag at that edge. A write with `flag_wdata` = 1 changes nothing. If the selected event and a clearing write arrive in the same cycle, the flag ends up set.
- R9: A set flag stays set across idle cycles and further events until a clearing write.
- R10: Switching to a code outside 100 to 111 discards the latched flag, so returning to a latched mode starts with the flag at 0.
- R11: `irq_flag` equals `irq_pull_low` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| tick_32k | input | 1 | One-cycle enable per 32.768 kHz tick |
| sec_inc | input | 1 | Second counter advanced |
| min_inc | input | 1 | Minute counter advanced |
| hour_inc | input | 1 | Hour counter advanced |
| month_inc | input | 1 | Month counter advanced |
| cycle_sel | input | 3 | Interrupt cycle code |
| flag_wr | input | 1 | Host write to the flag |
| flag_wdata | input | 1 | Written flag value (only 0 acts) |
| irq_pull_low | output | 1 | Enable for the open-drain low driver on the interrupt line |
| irq_flag | output | 1 | Readable interrupt flag |

## Verification
The bench re-aligns the divider with second strobes placed at odd phases and pauses the tick mid-wave. A divider that ignored the re-alignment, or counted without the tick enable, would move the square-wave edges away from the predicted cycle. In the latched modes it sends the wrong strobes, writes of 1, and an event in the same cycle as a clearing write. A design with a wrong priority or a wrong strobe decode would release the line early or assert it spuriously. It also leaves a latched mode while the flag is set and then comes back. A flag that survived the mode change would pull the line low with no new event.

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq #(
  parameter int unsigned TICKS_PER_SEC = 32768,
  parameter int unsigned SYNC_DELAY    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       sec_inc,
  input  logic       min_inc,
  input  logic       hour_inc,
  input  logic       month_inc,
  input  logic [2:0] cycle_sel,
  input  logic       flag_wr,
  input  logic       flag_wdata,
  output logic       irq_pull_low,
  output logic       irq_flag
);
  localparam int unsigned CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST_C  = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] HALF_C  = CW'(TICKS_PER_SEC / 2);
  localparam logic [CW-1:0] QUART_C = CW'(TICKS_PER_SEC / 4);
  localparam logic [CW-1:0] TQ_C    = CW'((TICKS_PER_SEC / 4) * 3);
  localparam logic [CW-1:0] SYNC_C  = CW'(SYNC_DELAY);

  logic [CW-1:0] phase_q;
  logic          latch_q;
  logic          live_q;
  logic          event_hit;
  logic          line_low;

  wire level_mode = cycle_sel[2];
  wire clear_req  = flag_wr & ~flag_wdata;
  wire low_1hz    = phase_q < HALF_C;
  wire low_2hz    = (phase_q < QUART_C) | ((phase_q >= HALF_C) & (phase_q < TQ_C));

  always_comb begin
    case (cycle_sel[1:0])
      2'd0:    event_hit = sec_inc;
      2'd1:    event_hit = min_inc;
      2'd2:    event_hit = hour_inc;
      default: event_hit = month_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (sec_inc) begin
      phase_q <= SYNC_C;
    end else if (tick_32k) begin
      phase_q <= (phase_q == LAST_C) ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (!level_mode)    latch_q <= 1'b0;
      else if (event_hit) latch_q <= 1'b1;
      else if (clear_req) latch_q <= 1'b0;
    end
  end

  always_comb begin
    case (cycle_sel)
      3'b000:  line_low = 1'b0;
      3'b001:  line_low = 1'b1;
      3'b010:  line_low = low_2hz;
      3'b011:  line_low = low_1hz;
      default: line_low = latch_q;
    endcase
  end

  assign irq_flag     = live_q & line_low;
  assign irq_pull_low = irq_flag;

  a_r2_off_released: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_sel == 3'b000 |-> !irq_pull_low);
  a_r3_fixed_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_sel == 3'b001 && live_q) |-> irq_pull_low);
  a_r4_resync_phase: assert property (@(posedge clk) disable iff (!rst_n)
    sec_inc |=> phase_q == SYNC_C);
  a_r6_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && event_hit) |=> latch_q);
  a_r8_write_one_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_q && !event_hit && flag_wr && flag_wdata) |=> !latch_q);
  a_r9_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && latch_q && !clear_req) |=> latch_q);
  a_r10_leave_discards: assert property (@(posedge clk) disable iff (!rst_n)
    !level_mode |=> !latch_q);
endmodule

// File: tb/test_rtc_periodic_irq.sv
module test_rtc_periodic_irq;
  localparam int PER = 16;
  localparam int DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_32k = 1'b1;
  logic sec_inc = 1'b0, min_inc = 1'b0, hour_inc = 1'b0, month_inc = 1'b0;
  logic [2:0] cycle_sel = 3'b001;
  logic flag_wr = 1'b0, flag_wdata = 1'b0;
  logic irq_pull_low, irq_flag;

  int compared = 0;
  int mismatched = 0;
  logic exp_q[$];
  string req_q[$];

  int m_cnt = 0;
  bit m_latch = 1'b0;
  bit m_live = 1'b0;

  always #5 clk = ~clk;

  rtc_periodic_irq #(.TICKS_PER_SEC(PER), .SYNC_DELAY(DLY)) i_rtc_periodic_irq (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .sec_inc(sec_inc),
    .min_inc(min_inc), .hour_inc(hour_inc), .month_inc(month_inc),
    .cycle_sel(cycle_sel), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .irq_pull_low(irq_pull_low), .irq_flag(irq_flag));

  task automatic check(input logic act, input logic exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit expect_line(input logic [2:0] sel);
    case (sel)
      3'b000: return 1'b0;
      3'b001: return 1'b1;
      3'b010: return ((m_cnt % (PER/2)) < PER/4);
      3'b011: return (m_cnt < PER/2);
      default: return m_latch;
    endcase
  endfunction

  task automatic cyc(input logic [2:0] sel, input logic t, input logic s, input logic mi,
                     input logic h, input logic mo, input logic w, input logic wd,
                     input string req);
    bit ev;
    @(negedge clk); #1;
    cycle_sel = sel; tick_32k = t; sec_inc = s; min_inc = mi; hour_inc = h;
    month_inc = mo; flag_wr = w; flag_wdata = wd;
    @(posedge clk); #1;
    m_live = 1'b1;
    case (sel[1:0])
      2'd0: ev = s;
      2'd1: ev = mi;
      2'd2: ev = h;
      default: ev = mo;
    endcase
    if (!sel[2]) m_latch = 1'b0;
    else if (ev) m_latch = 1'b1;
    else if (w && !wd) m_latch = 1'b0;
    if (s) m_cnt = DLY;
    else if (t) m_cnt = (m_cnt + 1) % PER;
    exp_q.push_back(m_live & expect_line(sel));
    req_q.push_back(req);
  endtask

  task automatic idle(input logic [2:0] sel, input int n, input string req);
    for (int i = 0; i < n; i++) cyc(sel, 1, 0, 0, 0, 0, 0, 0, req);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      check(irq_pull_low, e, r);
      check(irq_flag, irq_pull_low, "R11");
    end
  end

  initial begin
    #1500000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irq_pull_low, 1'b0, "R1");
    check(irq_flag, 1'b0, "R1");
    #1 rst_n = 1'b1;
    #1 check(irq_pull_low, 1'b0, "R1");

    // R2: idle code ignores every strobe
    cyc(3'b000, 1, 1, 1, 1, 1, 0, 0, "R2");
    idle(3'b000, 3, "R2");
    // R3: fixed low
    idle(3'b001, 4, "R3");
    cyc(3'b001, 1, 0, 0, 0, 0, 1, 0, "R3");

    // R4: 1 Hz, re-aligned by the second strobe, with a tick pause
    cyc(3'b011, 1, 1, 0, 0, 0, 0, 0, "R4");
    idle(3'b011, 20, "R4");
    for (int i = 0; i < 4; i++) cyc(3'b011, 0, 0, 0, 0, 0, 0, 0, "R4");
    idle(3'b011, 14, "R4");
    cyc(3'b011, 1, 1, 0, 0, 0, 0, 0, "R4");
    idle(3'b011, 18, "R4");

    // R5: 2 Hz, re-aligned mid-wave
    idle(3'b010, 11, "R5");
    cyc(3'b010, 1, 1, 0, 0, 0, 0, 0, "R5");
    idle(3'b010, 34, "R5");

    // R6 to R9: per-second latched mode
    cyc(3'b100, 1, 0, 1, 1, 1, 0, 0, "R7");
    idle(3'b100, 2, "R7");
    cyc(3'b100, 1, 1, 0, 0, 0, 0, 0, "R6");
    idle(3'b100, 5, "R9");
    cyc(3'b100, 1, 0, 0, 0, 0, 1, 1, "R8");
    cyc(3'b100, 1, 1, 0, 0, 0, 0, 0, "R9");
    idle(3'b100, 3, "R9");
    cyc(3'b100, 1, 0, 0, 0, 0, 1, 0, "R8");
    idle(3'b100, 2, "R8");
    cyc(3'b100, 1, 1, 0, 0, 0, 1, 0, "R8");
    idle(3'b100, 2, "R8");
    cyc(3'b100, 1, 0, 0, 0, 0, 1, 0, "R8");
    cyc(3'b100, 1, 0, 0, 0, 0, 1, 1, "R8");

    // R6/R7: minute, hour, month selection
    cyc(3'b101, 1, 1, 0, 1, 1, 0, 0, "R7");
    cyc(3'b101, 1, 0, 1, 0, 0, 0, 0, "R6");
    idle(3'b101, 2, "R9");
    cyc(3'b101, 1, 0, 0, 0, 0, 1, 0, "R8");
    cyc(3'b110, 1, 1, 1, 0, 1, 0, 0, "R7");
    cyc(3'b110, 1, 0, 0, 1, 0, 0, 0, "R6");
    idle(3'b110, 2, "R9");
    cyc(3'b110, 1, 0, 0, 0, 0, 1, 0, "R8");
    cyc(3'b111, 1, 1, 1, 1, 0, 0, 0, "R7");
    cyc(3'b111, 1, 0, 0, 0, 1, 0, 0, "R6");
    idle(3'b111, 2, "R9");

    // R10: leaving the latched mode discards the flag
    idle(3'b011, 3, "R10");
    idle(3'b111, 4, "R10");
    cyc(3'b111, 1, 0, 0, 0, 1, 0, 0, "R6");
    idle(3'b000, 2, "R10");
    idle(3'b111, 3, "R10");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule